// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block brings up and tears down the contacts of an asynchronous smart card in a fixed order. A session begins when the host drives the active-low session command low. The block then starts the supply pump and the card supply. It enables the data lines, starts the card clock, and finally hands the card reset line to the host. When the session command returns high, the same contacts are released in the reverse order. All timing is counted in oscillator cycles. One tick equals `TICK_CYC` cycles, 64 by default.

The block can run a clock-count-precise reset. If the host holds its reset request high when the session opens, the card clock is held off. It starts at the moment the request falls inside the window between tick 4 and tick 7. At tick 7 the card reset begins to copy the request. From then on the request has no influence on the clock.

Inside a session, card removal, overcurrent or overtemperature start an emergency teardown at once and pull the fault flag low. Removal is detected as any change on either presence contact. A supply alarm also tears the session down but leaves the fault flag high. A hold-off interval after the alarm keeps the block idle. Outside a session, the fault flag reports whether a card is present.

Top module: `card_contact_sequencer`

## Requirements
- R1: After reset all card outputs (pumpEn, vccEn, ioEn, clkEn, cardRst) are low. No activation starts until the hold-off of `HOLD_CYC` cycles has run out and the session command has been seen high at least once.
- R2: A low session command sampled on a clock edge raises pumpEn and vccEn after that edge. ioEn rises exactly 4·TICK_CYC cycles after pumpEn.
- R3: If rstReq is low when the session starts, clkEn rises together with ioEn. If rstReq is high at the start, clkEn rises in the same cycle that rstReq is seen low at or after the 4-tick point. It rises no later than the 7-tick point.
- R4: From 7·TICK_CYC cycles after pumpEn, cardRst equals rstReq and clkEn stays high whatever rstReq does. Before that point cardRst is low.
- R5: On teardown cardRst drops in the first cycle. clkEn stays on for TICK_CYC/2 cycles, ioEn for TICK_CYC, vccEn for 3·TICK_CYC and pumpEn for 5·TICK_CYC. An enable that was never on stays off.
- R6: An overcurrent or overtemperature pulse during a session drives faultN low from the next cycle and starts the R5 teardown at once.
- R7: A change on either presence contact (presN active low, pres active high) during a session acts like R6. The low faultN is held until the session command returns high.
- R8: A supply alarm during a session starts the R5 teardown while faultN stays high. After the alarm falls, no activation starts for `HOLD_CYC` cycles.
- R9: With the session command high and no session running, faultN is high when presN is low or pres is high, and low otherwise.
- R10: A session command that is low during or after a teardown does not restart the block. A new activation needs the command to be seen high after the teardown has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sessionN | input | 1 | Session command, low requests an active session |
| rstReq | input | 1 | Host reset request, also a clock gate during activation |
| presN | input | 1 | Card presence contact, active low |
| pres | input | 1 | Card presence contact, active high |
| supplyAlarm | input | 1 | Supply low alarm, active high |
| overCurrent | input | 1 | Card supply overload flag |
| overTemp | input | 1 | Thermal limit flag |
| pumpEn | output | 1 | Supply pump enable |
| vccEn | output | 1 | Card supply enable |
| ioEn | output | 1 | Data line enable |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset line |
| faultN | output | 1 | Multiplexed presence / fault flag, active low |

## Verification
State is registered on the edge that samples a command. Outputs are decoded combinationally from that state, the elapsed-cycle counter and the live request and presence inputs. So pumpEn, and any reaction to a fault or removal, shows one cycle after the stimulus. ioEn shows at step 1+4·TICK_CYC counted from the cycle in which the command is driven, and the reset hand-over at step 1+7·TICK_CYC. A drop of rstReq inside the window, or a presence change on faultN outside a session, shows in the same cycle. The bench drives inputs just after the falling edge and samples one time unit later. It counts steps from the drive and records the first and last step at which each enable is high. Those step numbers are compared with values computed from the tick count.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_LIVE = 2'd2,
    ST_DOWN = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } seqStrobe_t;
endpackage

// File: rtl/cardseq_timer.sv
module cardseq_timer
  import cardseq_pkg::*;
#(
  parameter int TICK_CYC = 64,
  parameter int HOLD_CYC = 25600,
  localparam int CNT_W = $clog2(8 * TICK_CYC + 1),
  localparam int HOLD_W = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             supplyAlarm,
  input  logic             presN,
  input  logic             pres,
  output logic [CNT_W-1:0] cnt,
  output logic             inhibit,
  output logic             presChange,
  output logic             cardPresent
);
  logic [HOLD_W-1:0] holdCnt;
  logic presNPrev;
  logic presPrev;

  // elapsed cycles within the current ramp or teardown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntRun) cnt <= cnt + 1'b1;
  end

  // hold-off after power-up and after every supply alarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= HOLD_W'(HOLD_CYC);
    else if (supplyAlarm) holdCnt <= HOLD_W'(HOLD_CYC);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presNPrev <= 1'b1;
      presPrev  <= 1'b0;
    end else begin
      presNPrev <= presN;
      presPrev  <= pres;
    end
  end

  assign inhibit     = supplyAlarm || (holdCnt != '0);
  assign presChange  = (presN != presNPrev) || (pres != presPrev);
  assign cardPresent = !presN || pres;
endmodule

// File: rtl/cardseq_ctrl.sv
module cardseq_ctrl
  import cardseq_pkg::*;
#(
  parameter int TICK_CYC = 64,
  localparam int CNT_W = $clog2(8 * TICK_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sessionN,
  input  logic             rstReq,
  input  logic             supplyAlarm,
  input  logic             overCurrent,
  input  logic             overTemp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             inhibit,
  input  logic             presChange,
  input  logic             cardPresent,
  output seqStrobe_t       strobe,
  output logic             pumpEn,
  output logic             vccEn,
  output logic             ioEn,
  output logic             clkEn,
  output logic             cardRst,
  output logic             faultN
);
  localparam logic [CNT_W-1:0] IO_AT    = CNT_W'(4 * TICK_CYC);
  localparam logic [CNT_W-1:0] LIVE_AT  = CNT_W'(7 * TICK_CYC - 1);
  localparam logic [CNT_W-1:0] CLK_OFF  = CNT_W'(TICK_CYC / 2);
  localparam logic [CNT_W-1:0] IO_OFF   = CNT_W'(TICK_CYC);
  localparam logic [CNT_W-1:0] VCC_OFF  = CNT_W'(3 * TICK_CYC);
  localparam logic [CNT_W-1:0] PUMP_OFF = CNT_W'(5 * TICK_CYC);
  localparam logic [CNT_W-1:0] DONE_AT  = CNT_W'(5 * TICK_CYC - 1);

  seqState_t state;
  logic armed;
  logic reqAtStart;
  logic reachedIo;
  logic reachedClk;
  logic faultLatch;

  logic inSession;
  logic hazard;
  logic abortNow;
  logic startNow;
  logic ioWin;
  logic rampClk;

  assign inSession = (state == ST_RAMP) || (state == ST_LIVE);
  assign hazard    = overCurrent || overTemp || presChange;
  assign abortNow  = inSession && (sessionN || supplyAlarm || hazard);
  assign startNow  = (state == ST_IDLE) && armed && !sessionN && !inhibit;
  assign ioWin     = (cnt >= IO_AT);
  assign rampClk   = ioWin && (!reqAtStart || reachedClk || !rstReq);

  always_comb begin
    strobe.cntClear = startNow || abortNow;
    strobe.cntRun   = (state == ST_RAMP) || (state == ST_DOWN);
  end

  always_comb begin
    pumpEn  = 1'b0;
    vccEn   = 1'b0;
    ioEn    = 1'b0;
    clkEn   = 1'b0;
    cardRst = 1'b0;
    unique case (state)
      ST_RAMP: begin
        pumpEn = 1'b1;
        vccEn  = 1'b1;
        ioEn   = ioWin;
        clkEn  = rampClk;
      end
      ST_LIVE: begin
        pumpEn  = 1'b1;
        vccEn   = 1'b1;
        ioEn    = 1'b1;
        clkEn   = 1'b1;
        cardRst = rstReq;
      end
      ST_DOWN: begin
        pumpEn = (cnt < PUMP_OFF);
        vccEn  = (cnt < VCC_OFF);
        ioEn   = reachedIo && (cnt < IO_OFF);
        clkEn  = reachedClk && (cnt < CLK_OFF);
      end
      default: ;
    endcase
    faultN = faultLatch ? 1'b0 : (sessionN ? cardPresent : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      reqAtStart <= 1'b0;
      reachedIo  <= 1'b0;
      reachedClk <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sessionN) armed <= 1'b1;
          if (startNow) begin
            state      <= ST_RAMP;
            armed      <= 1'b0;
            reqAtStart <= rstReq;
            reachedIo  <= 1'b0;
            reachedClk <= 1'b0;
          end
        end
        ST_RAMP: begin
          if (ioWin) reachedIo <= 1'b1;
          if (rampClk) reachedClk <= 1'b1;
          if (abortNow) state <= ST_DOWN;
          else if (cnt == LIVE_AT) state <= ST_LIVE;
        end
        ST_LIVE: begin
          reachedIo  <= 1'b1;
          reachedClk <= 1'b1;
          if (abortNow) state <= ST_DOWN;
        end
        ST_DOWN: begin
          if (cnt == DONE_AT) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // fault memory: cleared only when the session command is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultLatch <= 1'b0;
    else if (sessionN) faultLatch <= 1'b0;
    else if ((state != ST_IDLE) && hazard) faultLatch <= 1'b1;
  end
endmodule

// File: rtl/card_contact_sequencer.sv
module card_contact_sequencer
  import cardseq_pkg::*;
#(
  parameter int TICK_CYC = 64,
  parameter int HOLD_CYC = 25600
) (
  input  logic clk,
  input  logic rstN,
  input  logic sessionN,
  input  logic rstReq,
  input  logic presN,
  input  logic pres,
  input  logic supplyAlarm,
  input  logic overCurrent,
  input  logic overTemp,
  output logic pumpEn,
  output logic vccEn,
  output logic ioEn,
  output logic clkEn,
  output logic cardRst,
  output logic faultN
);
  localparam int CNT_W = $clog2(8 * TICK_CYC + 1);

  seqStrobe_t strobe;
  logic [CNT_W-1:0] cnt;
  logic inhibit;
  logic presChange;
  logic cardPresent;

  cardseq_timer #(.TICK_CYC(TICK_CYC), .HOLD_CYC(HOLD_CYC)) timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .supplyAlarm(supplyAlarm),
    .presN(presN), .pres(pres), .cnt(cnt), .inhibit(inhibit),
    .presChange(presChange), .cardPresent(cardPresent)
  );

  cardseq_ctrl #(.TICK_CYC(TICK_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .sessionN(sessionN), .rstReq(rstReq),
    .supplyAlarm(supplyAlarm), .overCurrent(overCurrent), .overTemp(overTemp),
    .cnt(cnt), .inhibit(inhibit), .presChange(presChange),
    .cardPresent(cardPresent), .strobe(strobe), .pumpEn(pumpEn),
    .vccEn(vccEn), .ioEn(ioEn), .clkEn(clkEn), .cardRst(cardRst),
    .faultN(faultN)
  );
endmodule

// File: rtl/card_contact_sequencer_chk.sv
module card_contact_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic sessionN,
  input logic rstReq,
  input logic presN,
  input logic pres,
  input logic supplyAlarm,
  input logic overCurrent,
  input logic overTemp,
  input logic pumpEn,
  input logic vccEn,
  input logic ioEn,
  input logic clkEn,
  input logic cardRst,
  input logic faultN
);
  assert_start_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpEn) |-> $past(!sessionN));

  assert_clk_inside_io_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> ioEn);

  assert_io_inside_vcc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ioEn |-> vccEn);

  assert_vcc_inside_pump_R5: assert property (@(posedge clk) disable iff (!rstN)
    vccEn |-> pumpEn);

  assert_fault_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpEn && !sessionN && (overCurrent || overTemp)) |=> !faultN);

  assert_fault_drops_rst_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cardRst && (overCurrent || overTemp)) |=> !cardRst);

  assert_rst_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> (rstReq && clkEn));

  assert_alarm_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (supplyAlarm && !pumpEn) |=> !pumpEn);

  assert_presence_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sessionN && $past(sessionN) && !pumpEn) |-> (faultN == (!presN || pres)));
endmodule

bind card_contact_sequencer card_contact_sequencer_chk chk (.*);

// File: tb/card_contact_sequencer_test.sv
module card_contact_sequencer_test;
  localparam int PERIOD = 10;
  localparam int TICK = 64;
  localparam int HOLD = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sessionN = 1'b1;
  logic rstReq = 1'b0;
  logic presN = 1'b0;
  logic pres = 1'b1;
  logic supplyAlarm = 1'b0;
  logic overCurrent = 1'b0;
  logic overTemp = 1'b0;
  logic pumpEn, vccEn, ioEn, clkEn, cardRst, faultN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  card_contact_sequencer #(.TICK_CYC(TICK), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rstN(rstN), .sessionN(sessionN), .rstReq(rstReq),
    .presN(presN), .pres(pres), .supplyAlarm(supplyAlarm),
    .overCurrent(overCurrent), .overTemp(overTemp), .pumpEn(pumpEn),
    .vccEn(vccEn), .ioEn(ioEn), .clkEn(clkEn), .cardRst(cardRst),
    .faultN(faultN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int expClkStep(input bit reqHigh, input int fall);
    if (!reqHigh || fall < 1 + 4 * TICK) return 1 + 4 * TICK;
    if (fall > 1 + 7 * TICK) return 1 + 7 * TICK;
    return fall;
  endfunction

  function automatic int expRstStep(input bit reqHigh, input int fall);
    return (reqHigh && fall > 1 + 7 * TICK) ? 1 + 7 * TICK : -1;
  endfunction

  function automatic int expFaultEnd(input int kind);
    return (kind >= 1 && kind <= 3) ? 0 : 1;
  endfunction

  // start a session at step 0 and follow it up to the live state
  task automatic activate(input bit reqHigh, input int fall);
    int firstPump = -1, firstIo = -1, firstClk = -1, firstRst = -1;
    @(negedge clk);
    rstReq = reqHigh;
    sessionN = 1'b0;
    for (int k = 1; k <= 7 * TICK + 3; k++) begin
      @(negedge clk);
      if (k == fall) rstReq = 1'b0;
      #1;
      if (pumpEn && firstPump < 0) firstPump = k;
      if (ioEn && firstIo < 0) firstIo = k;
      if (clkEn && firstClk < 0) firstClk = k;
      if (cardRst && firstRst < 0) firstRst = k;
    end
    chk("R2 pump start step", firstPump, 1);
    chk("R2 data line step", firstIo, 1 + 4 * TICK);
    chk("R3 clock start step", firstClk, expClkStep(reqHigh, fall));
    chk("R4 reset hand-over step", firstRst, expRstStep(reqHigh, fall));
    rstReq = 1'b1;
    #1;
    chk("R4 cardRst copies high", cardRst, 1);
    rstReq = 1'b0;
    #1;
    chk("R4 cardRst copies low", cardRst, 0);
    chk("R4 clock unaffected", clkEn, 1);
  endtask

  // kinds: 0 command, 1 overcurrent, 2 overtemp, 3 removal, 4 alarm, 5 re-request
  task automatic deact(input int kind);
    int lastClk = 0, lastIo = 0, lastVcc = 0, lastPump = 0, rst1 = 1;
    @(negedge clk);
    rstReq = 1'b1;
    #1;
    chk("R4 cardRst high before teardown", cardRst, 1);
    @(negedge clk);
    case (kind)
      1: overCurrent = 1'b1;
      2: overTemp = 1'b1;
      3: presN = ~presN;
      4: supplyAlarm = 1'b1;
      default: sessionN = 1'b1;
    endcase
    for (int k = 1; k <= 5 * TICK + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin overCurrent = 1'b0; overTemp = 1'b0; end
      if (k == 2 && kind == 5) sessionN = 1'b0;
      if (k == 3) supplyAlarm = 1'b0;
      #1;
      if (k == 1) begin
        rst1 = cardRst;
        if (kind >= 1 && kind <= 3) chk("R6 R7 fault flag next cycle", faultN, 0);
        if (kind == 4) chk("R8 alarm keeps flag high", faultN, 1);
      end
      if (clkEn) lastClk = k;
      if (ioEn) lastIo = k;
      if (vccEn) lastVcc = k;
      if (pumpEn) lastPump = k;
    end
    rstReq = 1'b0;
    chk("R5 cardRst drops first", rst1, 0);
    chk("R5 clock stop step", lastClk, TICK / 2);
    chk("R5 data line stop step", lastIo, TICK);
    chk("R5 supply stop step", lastVcc, 3 * TICK);
    chk("R5 pump stop step", lastPump, 5 * TICK);
    chk("R7 flag held to end", faultN, expFaultEnd(kind));
    if (kind != 0) begin
      adv(20);
      chk("R10 no restart while command low", pumpEn, 0);
      sessionN = 1'b1;
      adv(2);
      chk("R9 flag shows presence", faultN, (!presN || pres) ? 1 : 0);
      presN = 1'b0;
      pres = 1'b1;
      adv(2);
    end else begin
      adv(2);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int started;
    void'($urandom(32'h5eed_c0de));
    adv(3);
    chk("R1 pumpEn in reset", pumpEn, 0);
    chk("R1 vccEn in reset", vccEn, 0);
    chk("R1 ioEn in reset", ioEn, 0);
    chk("R1 clkEn in reset", clkEn, 0);
    chk("R1 cardRst in reset", cardRst, 0);
    rstN = 1'b1;
    // command low from reset on: never seen high, no start
    sessionN = 1'b0;
    adv(HOLD + 20);
    chk("R1 no start without high command", pumpEn, 0);
    sessionN = 1'b1;
    adv(2);
    chk("R9 both contacts asserted", faultN, 1);
    presN = 1'b1; pres = 1'b0;
    adv(1);
    chk("R9 no card", faultN, 0);
    pres = 1'b1;
    adv(1);
    chk("R9 high contact only", faultN, 1);
    presN = 1'b0; pres = 1'b0;
    adv(1);
    chk("R9 low contact only", faultN, 1);
    pres = 1'b1;
    adv(2);

    // directed corners of the clock window
    activate(1'b0, 0);
    deact(0);
    activate(1'b1, 1 + 5 * TICK);
    deact(1);
    activate(1'b1, 1 + 4 * TICK);
    deact(2);
    activate(1'b1, 1 + 8 * TICK);
    deact(3);
    activate(1'b1, 1 + 2 * TICK);
    deact(5);
    activate(1'b1, 1 + 7 * TICK);
    deact(0);

    // random sessions
    for (int i = 0; i < 8; i++) begin
      bit rh;
      int fl;
      int kd;
      rh = 1'($urandom % 2);
      fl = 1 + 3 * TICK + int'($urandom % (5 * TICK + 1));
      kd = int'($urandom % 4);
      activate(rh, fl);
      deact(kd);
    end

    // supply alarm and hold-off
    activate(1'b0, 0);
    deact(4);
    sessionN = 1'b0;
    adv(300);
    chk("R8 hold-off blocks start", pumpEn, 0);
    started = 0;
    for (int k = 0; k < 800; k++) begin
      adv(1);
      if (pumpEn) begin started = 1; break; end
    end
    chk("R8 start after hold-off", started, 1);
    adv(7 * TICK + 5);
    deact(0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule